// File: doc/BRIEF.md
# SPI Data Register Packing Front End

This block sits between a bus-facing data register and the serial shifter of an SPI controller. It holds a transmit FIFO and a receive FIFO of frames and converts between bus accesses and frames. The frame width can be set anywhere from 4 to 16 bits. Each bus access is either a byte or a halfword.

When frames are 8 bits or narrower, the block works in packed mode. A halfword write queues two frames and a byte write queues one. A halfword read takes two frames off the receive FIFO and joins them into one value. When frames are wider than 8 bits, every access moves exactly one frame.

The shifter is outside the block. It is represented by a frame-level valid/ready pair on each side. Two sticky error flags record transmit overflow and receive underrun. A not-empty indication on the receive side fires at a selectable fill level of one frame or two frames.

Top module: `spi_dr_pack`

## Requirements
- R1: After reset the following hold: `tx_empty`=1, `tx_valid`=0, both levels are 0, `rx_ready`=1, `rx_not_empty`=0, both sticky flags are 0, and `rd_data`=0.
- R2: The effective frame width is `frame_bits` clamped to the range 4..16. Every frame is stored with its bits above the effective width cleared, on both the transmit side and the receive side.
- R3: In packed mode (effective width <= 8), a halfword write (`wr_half`=1) queues two frames. The first frame is `wr_data[7:0]` and the second is `wr_data[15:8]`.
- R4: In packed mode, a byte write (`wr_half`=0) queues exactly one frame, taken from `wr_data[7:0]`. `wr_data[15:8]` has no effect.
- R5: In wide mode (effective width > 8), each write queues exactly one frame. A halfword write takes the frame from `wr_data[15:0]`. A byte write takes it from `wr_data[7:0]`, with the upper bits zero.
- R6: The transmit FIFO holds `DEPTH` frames (4 by default). If a write needs more frames than there is free room, it queues nothing and sets `ovf_flag`.
- R7: `tx_valid` is high while the transmit FIFO holds at least one frame. `tx_frame` presents the oldest frame. A cycle with `tx_valid` and `tx_ready` both high removes that frame.
- R8: `rx_ready` is high while the receive FIFO holds fewer than `DEPTH` frames. A frame offered while the FIFO is full is not stored.
- R9: With `rx_thresh_half`=0, `rx_not_empty` means one or more frames are held. With `rx_thresh_half`=1, it means two or more frames are held.
- R10: In packed mode, a halfword read removes two frames. It returns the first-received frame in `rd_data[7:0]` and the second in `rd_data[15:8]`. A byte read, or any read in wide mode, removes one frame and returns it right-aligned. `rd_data` is registered and changes on the clock edge that samples `rd_en`.
- R11: A read that needs more frames than are held returns 0 in `rd_data`, removes nothing, and sets `udr_flag`.
- R12: A `clr_flags` pulse clears both sticky flags. If an error occurs in the same cycle as the pulse, its flag is still set.
- R13: `tx_level`, `tx_empty`, `rx_level` and `rx_not_empty` reflect a push or a removal from the clock edge on which it happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_bits | input | 5 | Frame width in bits (clamped 4..16) |
| rx_thresh_half | input | 1 | 1: not-empty needs two frames; 0: one frame |
| wr_en | input | 1 | Data register write strobe |
| wr_half | input | 1 | Write access size: 1 halfword, 0 byte |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Data register read strobe |
| rd_half | input | 1 | Read access size: 1 halfword, 0 byte |
| rd_data | output | 16 | Read result, registered |
| clr_flags | input | 1 | Clear pulse for the sticky flags |
| tx_valid | output | 1 | Transmit frame available to the shifter |
| tx_frame | output | 16 | Oldest transmit frame |
| tx_ready | input | 1 | Shifter accepts the transmit frame |
| rx_valid | input | 1 | Shifter offers a received frame |
| rx_frame | input | 16 | Received frame |
| rx_ready | output | 1 | Receive FIFO has room |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_level | output | 3 | Frames held in the transmit FIFO |
| rx_level | output | 3 | Frames held in the receive FIFO |
| rx_not_empty | output | 1 | Receive fill at or above the threshold |
| ovf_flag | output | 1 | Sticky transmit overflow |
| udr_flag | output | 1 | Sticky receive underrun |

## Verification
Suppose a pointer or level register inside a FIFO goes wrong. The damage appears at the very next frame boundary: `tx_frame` shows a stale or out-of-order value, or `rd_data` returns the wrong bytes in the read cycle itself. If the level count drifts, the error appears in the same cycle: `tx_empty` or `rx_not_empty` becomes inconsistent with the number of frames pushed and removed. A write that is rejected wrongly, or accepted wrongly, changes `tx_level` on that edge, and the bench compares it against a count it keeps itself. Byte-ordering mistakes in packing cannot be seen until the frames are drained, so every packed write is followed by a drain that checks each frame's value and position.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;
    localparam int unsigned FRAME_MAX = 16;
    localparam int unsigned FRAME_MIN = 4;
    localparam int unsigned BYTE_BITS = 8;

    typedef enum logic [0:0] {
        ACC_BYTE = 1'b0,
        ACC_HALF = 1'b1
    } acc_size_e;

    function automatic int unsigned eff_bits(input logic [4:0] fb);
        if (int'(fb) < int'(FRAME_MIN))      return FRAME_MIN;
        else if (int'(fb) > int'(FRAME_MAX)) return FRAME_MAX;
        else                                 return int'(fb);
    endfunction

    function automatic logic [FRAME_MAX-1:0] low_mask(input int unsigned n);
        logic [FRAME_MAX-1:0] m;
        for (int i = 0; i < int'(FRAME_MAX); i++) m[i] = (i < int'(n));
        return m;
    endfunction
endpackage

// File: rtl/spi_dr_fifo.sv
module spi_dr_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    parameter int HEADS = 1,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           push_cnt,
    input  logic [W-1:0]         push_d0,
    input  logic [W-1:0]         push_d1,
    input  logic [1:0]           pop_cnt,
    output logic [HEADS*W-1:0]   heads,
    output logic [LW-1:0]        level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            wp    <= wp + AW'(push_cnt);
            rp    <= rp + AW'(pop_cnt);
            level <= level + LW'(push_cnt) - LW'(pop_cnt);
        end
    end

    always_ff @(posedge clk) begin
        if (push_cnt != 2'd0) mem[wp] <= push_d0;
        if (push_cnt == 2'd2) mem[wp + AW'(1)] <= push_d1;
    end

    assign heads[W-1:0] = mem[rp];
    generate
        if (HEADS == 2) begin : g_second_head
            assign heads[2*W-1:W] = mem[rp + AW'(1)];
        end
    endgenerate
endmodule

// File: rtl/spi_dr_txpack.sv
module spi_dr_txpack
    import spi_dr_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic [4:0]           frame_bits,
    input  logic                 wr_en,
    input  logic                 wr_half,
    input  logic [15:0]          wr_data,
    input  logic [LW-1:0]        tx_level,
    output logic [1:0]           push_cnt,
    output logic [15:0]          d0,
    output logic [15:0]          d1,
    output logic                 reject
);
    logic        packed_mode;
    logic [15:0] mask, base;
    logic [1:0]  need;

    always_comb begin
        packed_mode = eff_bits(frame_bits) <= BYTE_BITS;
        mask        = low_mask(eff_bits(frame_bits));
        base        = (acc_size_e'(wr_half) == ACC_HALF) ? wr_data : {8'h00, wr_data[7:0]};
        need        = (packed_mode && wr_half) ? 2'd2 : 2'd1;
        d0          = packed_mode ? ({8'h00, base[7:0]} & mask) : (base & mask);
        d1          = {8'h00, base[15:8]} & mask;
        reject      = wr_en && ((int'(tx_level) + int'(need)) > DEPTH);
        push_cnt    = (wr_en && !reject) ? need : 2'd0;
    end
endmodule

// File: rtl/spi_dr_rxunpack.sv
module spi_dr_rxunpack
    import spi_dr_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic [4:0]           frame_bits,
    input  logic                 rd_en,
    input  logic                 rd_half,
    input  logic [LW-1:0]        rx_level,
    input  logic [31:0]          heads,
    output logic [1:0]           pop_cnt,
    output logic [15:0]          rd_value,
    output logic                 short_rd
);
    logic       packed_mode;
    logic [1:0] need;

    always_comb begin
        packed_mode = eff_bits(frame_bits) <= BYTE_BITS;
        need        = (packed_mode && acc_size_e'(rd_half) == ACC_HALF) ? 2'd2 : 2'd1;
        short_rd    = rd_en && (int'(rx_level) < int'(need));
        pop_cnt     = (rd_en && !short_rd) ? need : 2'd0;
        if (short_rd)
            rd_value = 16'h0000;
        else if (need == 2'd2)
            rd_value = heads[15:0] | (heads[31:16] << 8);
        else
            rd_value = heads[15:0];
    end
endmodule

// File: rtl/spi_dr_pack.sv
module spi_dr_pack
    import spi_dr_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    frame_bits,
    input  logic          rx_thresh_half,
    input  logic          wr_en,
    input  logic          wr_half,
    input  logic [15:0]   wr_data,
    input  logic          rd_en,
    input  logic          rd_half,
    output logic [15:0]   rd_data,
    input  logic          clr_flags,
    output logic          tx_valid,
    output logic [15:0]   tx_frame,
    input  logic          tx_ready,
    input  logic          rx_valid,
    input  logic [15:0]   rx_frame,
    output logic          rx_ready,
    output logic          tx_empty,
    output logic [LW-1:0] tx_level,
    output logic [LW-1:0] rx_level,
    output logic          rx_not_empty,
    output logic          ovf_flag,
    output logic          udr_flag
);
    logic [1:0]  tx_push_cnt, tx_pop_cnt, rx_push_cnt, rx_pop_cnt;
    logic [15:0] tx_d0, tx_d1, rx_stored, rd_value;
    logic [31:0] rx_heads;
    logic        tx_reject, rd_short;

    spi_dr_txpack #(.DEPTH(DEPTH)) u_pack (
        .frame_bits(frame_bits), .wr_en(wr_en), .wr_half(wr_half),
        .wr_data(wr_data), .tx_level(tx_level), .push_cnt(tx_push_cnt),
        .d0(tx_d0), .d1(tx_d1), .reject(tx_reject)
    );

    spi_dr_fifo #(.W(16), .DEPTH(DEPTH), .HEADS(1)) u_txq (
        .clk(clk), .rst_n(rst_n), .push_cnt(tx_push_cnt), .push_d0(tx_d0),
        .push_d1(tx_d1), .pop_cnt(tx_pop_cnt), .heads(tx_frame), .level(tx_level)
    );

    assign tx_empty   = (tx_level == '0);
    assign tx_valid   = !tx_empty;
    assign tx_pop_cnt = (tx_valid && tx_ready) ? 2'd1 : 2'd0;

    assign rx_ready    = (int'(rx_level) < DEPTH);
    assign rx_stored   = rx_frame & low_mask(eff_bits(frame_bits));
    assign rx_push_cnt = (rx_valid && rx_ready) ? 2'd1 : 2'd0;

    spi_dr_fifo #(.W(16), .DEPTH(DEPTH), .HEADS(2)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push_cnt(rx_push_cnt), .push_d0(rx_stored),
        .push_d1(16'h0000), .pop_cnt(rx_pop_cnt), .heads(rx_heads), .level(rx_level)
    );

    spi_dr_rxunpack #(.DEPTH(DEPTH)) u_unpack (
        .frame_bits(frame_bits), .rd_en(rd_en), .rd_half(rd_half),
        .rx_level(rx_level), .heads(rx_heads), .pop_cnt(rx_pop_cnt),
        .rd_value(rd_value), .short_rd(rd_short)
    );

    assign rx_not_empty = rx_thresh_half ? (int'(rx_level) >= 2) : (rx_level != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            ovf_flag <= 1'b0;
            udr_flag <= 1'b0;
        end else begin
            if (rd_en) rd_data <= rd_value;
            ovf_flag <= (ovf_flag && !clr_flags) || tx_reject;
            udr_flag <= (udr_flag && !clr_flags) || rd_short;
        end
    end
endmodule

// File: rtl/spi_dr_pack_chk.sv
module spi_dr_pack_chk #(
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [4:0]    frame_bits,
    input logic          wr_en,
    input logic          wr_half,
    input logic          rd_en,
    input logic          clr_flags,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [15:0]   tx_frame,
    input logic          rx_ready,
    input logic          tx_empty,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic          rx_not_empty,
    input logic          ovf_flag,
    input logic          udr_flag
);
    a_r6_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tx_level) <= DEPTH);

    a_r6_reject_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_half && frame_bits >= 5'd4 && frame_bits <= 5'd8 &&
         int'(tx_level) > DEPTH - 2) |=> ovf_flag);

    a_r7_head_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !wr_en) |=> $stable(tx_frame));

    a_r1_empty_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> !tx_valid);

    a_r8_full_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> int'(rx_level) == DEPTH);

    a_r9_flag_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_not_empty |-> rx_level != '0);

    a_r11_udr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(udr_flag) |-> $past(rd_en));

    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flags && !rd_en && !wr_en) |=> (!udr_flag && !ovf_flag));
endmodule

bind spi_dr_pack spi_dr_pack_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_bits(frame_bits), .wr_en(wr_en),
    .wr_half(wr_half), .rd_en(rd_en), .clr_flags(clr_flags),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_frame(tx_frame),
    .rx_ready(rx_ready), .tx_empty(tx_empty), .tx_level(tx_level),
    .rx_level(rx_level), .rx_not_empty(rx_not_empty),
    .ovf_flag(ovf_flag), .udr_flag(udr_flag)
);

// File: tb/sim_spi_dr_pack.sv
module sim_spi_dr_pack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  frame_bits = 5'd8;
    logic        rx_thresh_half = 1'b0;
    logic        wr_en = 1'b0, wr_half = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0, rd_half = 1'b0;
    logic [15:0] rd_data;
    logic        clr_flags = 1'b0;
    logic        tx_valid, tx_ready = 1'b0;
    logic [15:0] tx_frame;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_frame = '0;
    logic        rx_ready, tx_empty, rx_not_empty, ovf_flag, udr_flag;
    logic [2:0]  tx_level, rx_level;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    spi_dr_pack u0 (
        .clk(clk), .rst_n(rst_n), .frame_bits(frame_bits), .rx_thresh_half(rx_thresh_half),
        .wr_en(wr_en), .wr_half(wr_half), .wr_data(wr_data), .rd_en(rd_en),
        .rd_half(rd_half), .rd_data(rd_data), .clr_flags(clr_flags),
        .tx_valid(tx_valid), .tx_frame(tx_frame), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_frame(rx_frame), .rx_ready(rx_ready),
        .tx_empty(tx_empty), .tx_level(tx_level), .rx_level(rx_level),
        .rx_not_empty(rx_not_empty), .ovf_flag(ovf_flag), .udr_flag(udr_flag)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic half, input logic [15:0] d);
        wr_en = 1'b1; wr_half = half; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic half);
        rd_en = 1'b1; rd_half = half;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rx_push(input logic [15:0] d);
        rx_valid = 1'b1; rx_frame = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pop_expect(input string req, input logic [15:0] exp);
        check({req, " tx_valid"}, {15'd0, tx_valid}, 16'd1);
        check({req, " tx_frame"}, tx_frame, exp);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic clear_flags();
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 tx_empty", {15'd0, tx_empty}, 16'd1);
        check("R1 tx_valid", {15'd0, tx_valid}, 16'd0);
        check("R1 tx_level", {13'd0, tx_level}, 16'd0);
        check("R1 rx_level", {13'd0, rx_level}, 16'd0);
        check("R1 rx_ready", {15'd0, rx_ready}, 16'd1);
        check("R1 rx_not_empty", {15'd0, rx_not_empty}, 16'd0);
        check("R1 flags", {14'd0, ovf_flag, udr_flag}, 16'd0);
        check("R1 rd_data", rd_data, 16'd0);
    endtask

    task automatic t_packed_writes();
        frame_bits = 5'd8;
        wr(1'b1, 16'h1234);
        check("R3 R13 level after halfword", {13'd0, tx_level}, 16'd2);
        check("R13 tx_empty after push", {15'd0, tx_empty}, 16'd0);
        pop_expect("R3 first low byte", 16'h0034);
        check("R13 level after pop", {13'd0, tx_level}, 16'd1);
        pop_expect("R3 second high byte", 16'h0012);
        check("R7 empty after drain", {15'd0, tx_empty}, 16'd1);
        wr(1'b0, 16'hFFA5);
        check("R4 byte write one frame", {13'd0, tx_level}, 16'd1);
        pop_expect("R4 byte value", 16'h00A5);
    endtask

    task automatic t_widths();
        frame_bits = 5'd5;
        wr(1'b0, 16'h00FF);
        pop_expect("R2 5-bit byte", 16'h001F);
        wr(1'b1, 16'hE7FF);
        check("R2 R3 5-bit halfword count", {13'd0, tx_level}, 16'd2);
        pop_expect("R2 5-bit first", 16'h001F);
        pop_expect("R2 5-bit second", 16'h0007);
        frame_bits = 5'd2;
        wr(1'b0, 16'h00FF);
        pop_expect("R2 clamp to 4", 16'h000F);
        frame_bits = 5'd12;
        wr(1'b1, 16'hABCD);
        check("R5 wide halfword one frame", {13'd0, tx_level}, 16'd1);
        pop_expect("R5 wide halfword", 16'h0BCD);
        wr(1'b0, 16'hABCD);
        pop_expect("R5 wide byte", 16'h00CD);
        frame_bits = 5'd31;
        wr(1'b1, 16'hBEEF);
        pop_expect("R2 clamp to 16", 16'hBEEF);
    endtask

    task automatic t_overflow();
        frame_bits = 5'd8;
        wr(1'b0, 16'h0001);
        wr(1'b0, 16'h0002);
        wr(1'b0, 16'h0003);
        wr(1'b1, 16'h5566);
        check("R6 rejected halfword level", {13'd0, tx_level}, 16'd3);
        check("R6 ovf set", {15'd0, ovf_flag}, 16'd1);
        wr(1'b0, 16'h0004);
        check("R6 fits last byte", {13'd0, tx_level}, 16'd4);
        wr(1'b0, 16'h0009);
        check("R6 full rejects byte", {13'd0, tx_level}, 16'd4);
        for (int i = 1; i <= 4; i++) pop_expect("R6 R7 order", 16'(i));
        clear_flags();
        check("R12 ovf cleared", {15'd0, ovf_flag}, 16'd0);
    endtask

    task automatic t_rx_packed();
        frame_bits = 5'd8;
        rx_thresh_half = 1'b1;
        rx_push(16'h0011);
        check("R13 rx_level one", {13'd0, rx_level}, 16'd1);
        check("R9 half threshold one frame", {15'd0, rx_not_empty}, 16'd0);
        rx_push(16'h0022);
        check("R9 half threshold two frames", {15'd0, rx_not_empty}, 16'd1);
        rd(1'b1);
        check("R10 halfword read", rd_data, 16'h2211);
        check("R10 level after halfword read", {13'd0, rx_level}, 16'd0);
        rd(1'b0);
        check("R11 empty read data", rd_data, 16'h0000);
        check("R11 udr set", {15'd0, udr_flag}, 16'd1);
        clear_flags();
        check("R12 udr cleared", {15'd0, udr_flag}, 16'd0);
        rx_thresh_half = 1'b0;
        rx_push(16'h0033);
        check("R9 one-frame threshold", {15'd0, rx_not_empty}, 16'd1);
        rd(1'b1);
        check("R11 short halfword data", rd_data, 16'h0000);
        check("R11 short halfword keeps level", {13'd0, rx_level}, 16'd1);
        check("R11 short halfword udr", {15'd0, udr_flag}, 16'd1);
        rd(1'b0);
        check("R10 byte read", rd_data, 16'h0033);
        clr_flags = 1'b1;
        rd(1'b0);
        clr_flags = 1'b0;
        check("R12 event beats clear", {15'd0, udr_flag}, 16'd1);
        clear_flags();
    endtask

    task automatic t_rx_full_wide();
        frame_bits = 5'd8;
        for (int i = 0; i < 4; i++) rx_push(16'h00A0 + 16'(i));
        check("R8 full not ready", {15'd0, rx_ready}, 16'd0);
        rx_push(16'h00EE);
        check("R8 extra frame dropped", {13'd0, rx_level}, 16'd4);
        for (int i = 0; i < 4; i++) begin
            rd(1'b0);
            check("R8 R10 rx order", rd_data, 16'h00A0 + 16'(i));
        end
        frame_bits = 5'd12;
        rx_push(16'hFABC);
        rd(1'b1);
        check("R2 R10 wide read masked", rd_data, 16'h0ABC);
        check("R10 wide read one frame", {13'd0, rx_level}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_packed_writes();
        t_widths();
        t_overflow();
        t_rx_packed();
        t_rx_full_wide();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule